// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Flags

This block raises and drops the two cross-port interrupt lines of a dual-port memory. The topmost word of the address space is the mailbox of the right port, and the word just below it is the mailbox of the left port. When one port writes into the other port's mailbox, the other port's interrupt goes active. The receiving port drops its own interrupt by reading its mailbox.

The mailbox words are ordinary memory locations and hold user data of full word width. This block does not store them. It only watches each port's address, select, write strobe and output enable. It updates two flag registers on the clock edge, and drives both interrupt outputs active low. Each port has a busy input. While a port's busy input is asserted, any set or clear that port would cause is vetoed. A synchronous reset gives the flags a defined start state.

Top module: `mbox_irq`

## Requirements
- R1: While `rst` is high at a clock edge, both `l_irq_n` and `r_irq_n` are 1 after that edge.
- R2: A cycle with `l_sel`=1, `l_wr`=1, `l_busy`=0 and `l_addr` all ones drives `r_irq_n` to 0 after the next edge.
- R3: A cycle with `r_sel`=1, `r_wr`=1, `r_busy`=0 and `r_addr` equal to all ones minus one drives `l_irq_n` to 0 after the next edge.
- R4: A cycle with `r_sel`=1, `r_oe`=1, `r_busy`=0 and `r_addr` all ones drives `r_irq_n` to 1 after the next edge, whatever the value of `r_wr`.
- R5: A cycle with `l_sel`=1, `l_oe`=1, `l_busy`=0 and `l_addr` equal to all ones minus one drives `l_irq_n` to 1 after the next edge, whatever the value of `l_wr`.
- R6: While a port's busy input is 1, that port can neither set the other port's flag nor clear its own flag.
- R7: When a set and a clear of the same flag fall in the same cycle, the flag ends up set (output 0).
- R8: No other access changes a flag. This covers accesses to other addresses, accesses with select 0, a write by a port into its own mailbox, and a read of the other port's mailbox.
- R9: With no set or clear pending, each flag holds its value from one edge to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| l_addr | input | ADDR_W | Left port address |
| l_sel | input | 1 | Left port selected |
| l_wr | input | 1 | Left port write strobe |
| l_oe | input | 1 | Left port output enable |
| l_busy | input | 1 | Left port busy, vetoes left actions |
| r_addr | input | ADDR_W | Right port address |
| r_sel | input | 1 | Right port selected |
| r_wr | input | 1 | Right port write strobe |
| r_oe | input | 1 | Right port output enable |
| r_busy | input | 1 | Right port busy, vetoes right actions |
| l_irq_n | output | 1 | Left interrupt, active low |
| r_irq_n | output | 1 | Right interrupt, active low |

## Verification
The hardest case to reach is a set and a clear of the same flag landing in one cycle. That only happens when the writer hits the other mailbox at the same moment the owner reads it. The stimulus table therefore holds vectors that drive both ports together onto the same mailbox. It also holds vectors where the clearing read has its write strobe raised, so a write into the port's own mailbox is shown to clear rather than set.

// File: rtl/mbox_irq.sv
module mbox_irq #(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              l_sel,
  input  logic              l_wr,
  input  logic              l_oe,
  input  logic              l_busy,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              r_sel,
  input  logic              r_wr,
  input  logic              r_oe,
  input  logic              r_busy,
  output logic              l_irq_n,
  output logic              r_irq_n
);

  localparam logic [ADDR_W-1:0] BOX_R = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] BOX_L = BOX_R - 1'b1;

  logic l_pend, r_pend;
  logic set_l, clr_l, set_r, clr_r;

  assign set_r = l_sel && l_wr && !l_busy && (l_addr == BOX_R);
  assign clr_r = r_sel && r_oe && !r_busy && (r_addr == BOX_R);
  assign set_l = r_sel && r_wr && !r_busy && (r_addr == BOX_L);
  assign clr_l = l_sel && l_oe && !l_busy && (l_addr == BOX_L);

  always_ff @(posedge clk) begin
    if (rst) begin
      l_pend <= 1'b0;
      r_pend <= 1'b0;
    end else begin
      if (set_l)      l_pend <= 1'b1;
      else if (clr_l) l_pend <= 1'b0;
      if (set_r)      r_pend <= 1'b1;
      else if (clr_r) r_pend <= 1'b0;
    end
  end

  assign l_irq_n = !l_pend;
  assign r_irq_n = !r_pend;

  assert_reset_R1: assert property (@(posedge clk) rst |=> (l_irq_n && r_irq_n));

  assert_left_writes_R2: assert property (@(posedge clk) disable iff (rst)
    (l_sel && l_wr && !l_busy && l_addr == {ADDR_W{1'b1}}) |=> !r_irq_n);

  assert_right_writes_R3: assert property (@(posedge clk) disable iff (rst)
    (r_sel && r_wr && !r_busy && r_addr == {ADDR_W{1'b1}} - 1'b1) |=> !l_irq_n);

  assert_right_reads_R4: assert property (@(posedge clk) disable iff (rst)
    (r_sel && r_oe && !r_busy && r_addr == {ADDR_W{1'b1}} &&
     !(l_sel && l_wr && !l_busy && l_addr == {ADDR_W{1'b1}})) |=> r_irq_n);

  assert_left_reads_R5: assert property (@(posedge clk) disable iff (rst)
    (l_sel && l_oe && !l_busy && l_addr == {ADDR_W{1'b1}} - 1'b1 &&
     !(r_sel && r_wr && !r_busy && r_addr == {ADDR_W{1'b1}} - 1'b1)) |=> l_irq_n);

  assert_busy_no_set_R6: assert property (@(posedge clk) disable iff (rst)
    (l_busy && r_irq_n) |=> r_irq_n);

  assert_busy_no_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (r_busy && !r_irq_n) |=> !r_irq_n);

  assert_hold_r_R9: assert property (@(posedge clk) disable iff (rst)
    (!(l_sel && l_wr && l_addr == {ADDR_W{1'b1}}) &&
     !(r_sel && r_oe && r_addr == {ADDR_W{1'b1}})) |=> $stable(r_irq_n));

  assert_hold_l_R8: assert property (@(posedge clk) disable iff (rst)
    (!(r_sel && r_wr && r_addr == {ADDR_W{1'b1}} - 1'b1) &&
     !(l_sel && l_oe && l_addr == {ADDR_W{1'b1}} - 1'b1)) |=> $stable(l_irq_n));

endmodule

// File: tb/mbox_irq_bench.sv
module mbox_irq_bench;
  localparam int AW = 17;
  localparam int NV = 18;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic l_sel = 0, l_wr = 0, l_oe = 0, l_busy = 0;
  logic r_sel = 0, r_wr = 0, r_oe = 0, r_busy = 0;
  logic l_irq_n, r_irq_n;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  mbox_irq #(.ADDR_W(AW)) u_mbox_irq (
    .clk(clk), .rst(rst),
    .l_addr(l_addr), .l_sel(l_sel), .l_wr(l_wr), .l_oe(l_oe), .l_busy(l_busy),
    .r_addr(r_addr), .r_sel(r_sel), .r_wr(r_wr), .r_oe(r_oe), .r_busy(r_busy),
    .l_irq_n(l_irq_n), .r_irq_n(r_irq_n)
  );

  // fields: l_code[13:12] l{sel,wr,oe,busy}[11:8] r_code[7:6] r{sel,wr,oe,busy}[5:2] exp{l_n,r_n}[1:0]
  // address codes: 0 all ones, 1 all ones minus one, 2 zero, 3 0x5A5
  localparam logic [13:0] VEC [NV] = '{
    14'b10_0000_10_0000_11, // R9 idle
    14'b00_1100_10_0000_10, // R2 left writes right mailbox
    14'b00_1100_10_0000_10, // R9 repeat keeps flag
    14'b10_0000_00_1011_10, // R6 busy right read does not clear
    14'b10_0000_00_1110_11, // R4 right clears with wr high
    14'b10_0000_01_1100_01, // R3 right writes left mailbox
    14'b00_1010_10_0000_01, // R8 left reads wrong mailbox
    14'b01_1010_10_0000_11, // R5 left clears
    14'b10_0000_01_1101_11, // R6 busy right write does not set
    14'b01_1100_10_0000_11, // R8 left writes own mailbox
    14'b10_0000_00_1100_11, // R8 right writes own mailbox
    14'b00_0100_10_0000_11, // R8 no select
    14'b11_1100_10_0000_11, // R8 ordinary address
    14'b01_1010_01_1100_01, // R7 set wins on left flag
    14'b00_1100_00_1010_00, // R7 set wins on right flag
    14'b01_1011_10_0000_00, // R6 busy left read does not clear
    14'b01_1110_10_0000_10, // R5 left clears with wr high
    14'b10_0000_00_1010_11  // R4 right clears
  };
  localparam int REQ [NV] = '{9, 2, 9, 6, 4, 3, 8, 5, 6, 8, 8, 8, 8, 7, 7, 6, 5, 4};

  function automatic logic [AW-1:0] pick(input logic [1:0] c);
    case (c)
      2'd0: pick = {AW{1'b1}};
      2'd1: pick = {AW{1'b1}} - 1'b1;
      2'd2: pick = '0;
      default: pick = AW'(12'h5A5);
    endcase
  endfunction

  task automatic check(input string req, input logic exp_l, input logic exp_r);
    checks++;
    if (l_irq_n !== exp_l || r_irq_n !== exp_r) begin
      errors++;
      $display("FAIL %s l_irq_n=%b r_irq_n=%b expected %b %b", req, l_irq_n, r_irq_n, exp_l, exp_r);
    end
  endtask

  task automatic idle_ports();
    l_sel = 0; l_wr = 0; l_oe = 0; l_busy = 0;
    r_sel = 0; r_wr = 0; r_oe = 0; r_busy = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 check("R1 reset", 1'b1, 1'b1);
    @(negedge clk) rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      l_addr = pick(VEC[i][13:12]);
      {l_sel, l_wr, l_oe, l_busy} = VEC[i][11:8];
      r_addr = pick(VEC[i][7:6]);
      {r_sel, r_wr, r_oe, r_busy} = VEC[i][5:2];
      @(posedge clk);
      #2 check($sformatf("R%0d vector %0d", REQ[i], i), VEC[i][1], VEC[i][0]);
    end
    // R1: reset clears both raised flags
    @(negedge clk);
    l_addr = pick(2'd0); l_sel = 1; l_wr = 1;
    r_addr = pick(2'd1); r_sel = 1; r_wr = 1;
    @(posedge clk);
    #2 check("R2 R3 both raised", 1'b0, 1'b0);
    @(negedge clk) begin idle_ports(); rst = 1'b1; end
    @(posedge clk);
    #2 check("R1 reset mid run", 1'b1, 1'b1);
    // R1: reset dominates a set in the same cycle
    @(negedge clk) begin l_addr = pick(2'd0); l_sel = 1; l_wr = 1; end
    @(posedge clk);
    #2 check("R1 reset over set", 1'b1, 1'b1);
    @(negedge clk) begin idle_ports(); rst = 1'b0; end
    repeat (2) @(posedge clk);
    #2 check("R9 idle after reset", 1'b1, 1'b1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule